// File: doc/BRIEF.md
# Flash Program and Erase Pulse Timer

This block times one flash program or erase operation. Software loads a time register holding an enable flag and a 15-bit count. It then writes a request to the control register. The block raises `busy` toward the array for exactly `count × 512 + 2` bus clock cycles. When that interval ends it sets the done and ready flags in a read-only status register. Software polls done before it issues the next sector erase or page program.

A second register holds a 12-bit divider value N. From it the block derives a programming-clock strobe, `prog_tick`, once every `3·N + 1` bus cycles; N must be chosen so that this lands near 66 kHz. All registers sit on a simple single-cycle register bus. Writes are taken on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`.

Top module: `flash_pulse_timer`

## Requirements
- R1: After reset: control reads 0x0005, status reads 0x0045, time and divider registers read 0, `busy` and `prog_tick` are not both required to be anything but `busy` is 0.
- R2: The time register at offset 0x08 is 16 bits wide and reads back as written: bit 15 is the enable flag and bits 14:0 are the count.
- R3: A write to control (offset 0x00) with bits 12 (request), 7 (protect) and 0 (chip select) all set starts an operation when the enable flag is set and no operation runs. `busy` is high after that clock edge. While the operation runs, status reads 0x0042: done bit 0 is clear, grant bit 1 is set and ready bit 2 is clear.
- R4: `busy` stays high for exactly count × 512 + 2 clock cycles. The count is sampled at the start, so later writes to the time register do not change the running operation.
- R5: On the edge where `busy` falls, done (bit 0) and ready (bit 2) are set and grant is cleared. Done and `busy` are never high together.
- R6: A request with the enable flag clear starts nothing, and done keeps its value.
- R7: A write to control that lacks protect or chip select does not start an operation.
- R8: A valid request made while an operation runs is ignored: the running interval does not change, and error bit 5 of status is set. The next accepted start clears the error bit.
- R9: Control bit 12 always reads 0. The other control bits read back as last written.
- R10: The divider register at 0x1C keeps only bits 11:0. `prog_tick` pulses once every 3·N + 1 cycles, and a write to the divider restarts the period.
- R11: Status is read-only. Reads of offsets with no register behind them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| busy | output | 1 | Operation in progress toward the array |
| prog_tick | output | 1 | One-cycle programming-clock strobe |

## Verification
A wrong remaining-cycle counter shows up as a `busy` interval that is a few cycles off. Such an error appears at the end of the very first operation, within about 500 cycles for a count of 1. A wrong done or error flag shows up at the next status read: during the run, right after the end, or right after an ignored request. A wrong divider state shows up as a wrong strobe spacing within two periods of a divider write.

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
  parameter int CW      = 15,
  parameter int PAGE_SH = 9,
  parameter int OVH     = 2,
  parameter int DW      = 12,
  parameter int AW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [CW:0]   bus_wdata,
  output logic [CW:0]   bus_rdata,
  output logic          busy,
  output logic          prog_tick
);
  localparam int XW = CW + 1;
  localparam int RW = CW + PAGE_SH + 1;
  localparam int LW = DW + 2;
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_STAT = AW'(8'h04);
  localparam logic [AW-1:0] A_TIME = AW'(8'h08);
  localparam logic [AW-1:0] A_CDIV = AW'(8'h1C);
  localparam int B_REQ = 12, B_PROT = 7, B_CS = 0;

  logic [XW-1:0] ctrl_q, time_q;
  logic [DW-1:0] cdiv_q;
  logic [RW-1:0] rem_q;
  logic [LW-1:0] dcnt_q;
  logic          done_q, err_q;

  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_cdiv = bus_we && bus_addr == A_CDIV;
  wire req     = wr_ctrl && bus_wdata[B_REQ] && bus_wdata[B_PROT] && bus_wdata[B_CS];
  wire start   = req && time_q[XW-1] && !busy;
  wire [LW-1:0] div_lim = (LW'(cdiv_q) << 1) + LW'(cdiv_q);

  assign busy      = rem_q != '0;
  assign prog_tick = dcnt_q == div_lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= XW'(16'h0005);
      time_q <= '0;
      cdiv_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_CTRL) ctrl_q <= bus_wdata & ~(XW'(1) << B_REQ);
      if (bus_addr == A_TIME) time_q <= bus_wdata;
      if (bus_addr == A_CDIV) cdiv_q <= bus_wdata[DW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rem_q  <= '0;
      done_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      if (start)
        rem_q <= (RW'(time_q[CW-1:0]) << PAGE_SH) + RW'(OVH);
      else if (busy)
        rem_q <= rem_q - 1'b1;
      if (start)              done_q <= 1'b0;
      else if (rem_q == RW'(1)) done_q <= 1'b1;
      if (start)              err_q <= 1'b0;
      else if (req && busy)   err_q <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    dcnt_q <= '0;
    else if (wr_cdiv || prog_tick) dcnt_q <= '0;
    else                           dcnt_q <= dcnt_q + 1'b1;

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_q;
      A_STAT:  bus_rdata = XW'({err_q, 2'b0, !busy, busy, done_q}) | XW'(16'h0040);
      A_TIME:  bus_rdata = time_q;
      A_CDIV:  bus_rdata = XW'(cdiv_q);
      default: bus_rdata = '0;
    endcase

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[B_REQ] && bus_wdata[B_PROT] && bus_wdata[B_CS] && time_q[XW-1] && !busy)
      |=> (busy && !done_q));
  p_done_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_q);
  p_no_busy_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_q);
  p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(wr_ctrl && time_q[XW-1])) |=> done_q == $past(done_q));
  p_err_on_busy_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_ctrl && bus_wdata[B_REQ] && bus_wdata[B_PROT] && bus_wdata[B_CS]) |=> err_q);
  p_tick_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_tick && !wr_cdiv && cdiv_q != '0) |=> !prog_tick);
endmodule

// File: tb/test_flash_pulse_timer.sv
module test_flash_pulse_timer;
  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic busy, prog_tick;
  int n_run = 0, n_fail = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  flash_pulse_timer i_flash_pulse_timer (.clk, .rst_n, .bus_addr, .bus_we,
    .bus_wdata, .bus_rdata, .busy, .prog_tick);

  // {write addr, write data, read addr, expected read}
  localparam logic [47:0] VEC [0:6] = '{
    {8'h08, 16'h8003, 8'h08, 16'h8003},  // R2
    {8'h08, 16'h7FFF, 8'h08, 16'h7FFF},  // R2
    {8'h1C, 16'hFFFF, 8'h1C, 16'h0FFF},  // R10
    {8'h00, 16'h0006, 8'h00, 16'h0006},  // R9
    {8'h00, 16'h1002, 8'h00, 16'h0002},  // R9 R7
    {8'h10, 16'h1234, 8'h10, 16'h0000},  // R11
    {8'h04, 16'hFFFF, 8'h04, 16'h0045}   // R11
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic measure(int inject, output int len);
    len = 0;
    while (busy && len < 100000) begin
      len++;
      if (len == inject) begin
        bus_addr = 8'h00; bus_wdata = 16'h1081; bus_we = 1;
      end
      @(negedge clk);
      bus_we = 0;
    end
  endtask

  task automatic tick_gap(output int gap);
    int w = 0;
    while (!prog_tick && w < 50) begin w++; @(negedge clk); end
    gap = 0;
    do begin gap++; @(negedge clk); end while (!prog_tick && gap < 50);
  endtask

  task automatic finish_up;
    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #3_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    logic [15:0] d;
    int len;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, d); chk("R1 ctrl", d, 16'h0005);
    rd(8'h04, d); chk("R1 status", d, 16'h0045);
    rd(8'h08, d); chk("R1 time", d, 0);
    rd(8'h1C, d); chk("R1 cdiv", d, 0);
    chk("R1 busy", busy, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][47:40], VEC[i][39:24]);
      rd(VEC[i][23:16], d);
      chk($sformatf("vector %0d", i), d, VEC[i][15:0]);
      chk("R7 no start", busy, 0);
    end

    // R6: enable clear (time = 0x7FFF)
    wr(8'h00, 16'h1081);
    chk("R6 busy", busy, 0);
    rd(8'h04, d); chk("R6 status", d, 16'h0045);

    // R7: missing protect, then missing chip select
    wr(8'h08, 16'h8001);
    wr(8'h00, 16'h1001); chk("R7 no prot", busy, 0);
    wr(8'h00, 16'h1080); chk("R7 no cs", busy, 0);

    // R3 R4 R5: count 1
    wr(8'h00, 16'h1083);
    chk("R3 busy", busy, 1);
    rd(8'h04, d); chk("R3 status", d, 16'h0042);
    wr(8'h08, 16'h8005);  // R4: mid-run change has no effect
    measure(0, len);
    chk("R4 len cnt1", len, 514 - 1);
    rd(8'h04, d); chk("R5 status", d, 16'h0045);

    // R4 count 0 and count 3
    wr(8'h08, 16'h8000);
    wr(8'h00, 16'h1081); measure(0, len); chk("R4 len cnt0", len, 2);
    wr(8'h08, 16'h8003);
    wr(8'h00, 16'h1081); measure(0, len); chk("R4 len cnt3", len, 3*512+2);

    // R8: request while busy
    wr(8'h00, 16'h1081); measure(10, len);
    chk("R8 len", len, 3*512+2);
    rd(8'h04, d); chk("R8 err", d, 16'h0065);
    wr(8'h08, 16'h8000);
    wr(8'h00, 16'h1081);
    rd(8'h04, d); chk("R8 err clear", d, 16'h0042);
    measure(0, len);

    // R10: strobe spacing
    wr(8'h1C, 16'h0002); tick_gap(len); chk("R10 N=2", len, 7);
    wr(8'h1C, 16'h0000); tick_gap(len); chk("R10 N=0", len, 1);
    wr(8'h1C, 16'h0005); tick_gap(len); chk("R10 N=5", len, 16);

    finish_up();
  end
endmodule